// File: doc/BRIEF.md
# Ternary-Weight INT8 Dot-Product Engine

This block forms the dot product of a signed 8-bit activation vector and a vector of ternary weights (-1, 0, +1) without instantiating any multiplier. Weights arrive packed as four 2-bit codes per byte. Each code either adds its activation to the running sum, subtracts it, or skips it. Four lanes handle one packed byte and four activations per accepted beat. An adder tree combines the four lane results, and the tree output is added into an integer accumulator.

To use the block, a caller pulses `start_i` with the element count on `len_i`. The caller then presents ceil(len/4) beats on `valid_i`, each beat carrying one weight byte and four activations. One cycle after the beat that completes the vector, the block raises `done_o` for a single cycle and places the signed result on `sum_o`. An error flag on `err_o` reports whether any in-range weight used the reserved code.

The accumulator is 8 + ceil(log2(MAX_LEN)) + 1 bits wide, so even the worst-case sum cannot wrap.

Top module: `tern_dot_engine`

## Requirements
- R1: Weight code 2'b01 adds the paired activation to the sum, 2'b11 subtracts it, and 2'b00 contributes nothing. Activations are two's-complement signed 8-bit values.
- R2: Within a beat, weight bits [2k+1:2k] pair with activation bits [8k+7:8k] for lane k = 0..3. Lane 0 is the earliest element of the beat, and beats follow in element order.
- R3: `sum_o` is 8 + ceil(log2(MAX_LEN)) + 1 bits wide, and it returns the exact result for every input, including +128*MAX_LEN and -128*MAX_LEN.
- R4: Code 2'b10 on an in-range element is treated as a zero weight. `err_o` is then high together with the `done_o` pulse of that vector. `err_o` is low at every other time.
- R5: Lanes past the vector length in the final beat are ignored whatever their codes or activations, and they never set `err_o`.
- R6: A vector of length L takes ceil(L/4) beats. `done_o` is a one-cycle pulse in the cycle after the clock edge that accepts the last beat, and it stays low before that.
- R7: Cycles with `valid_i` low add nothing and do not end a vector. Beats presented while no vector is open are ignored: they raise no `done_o` and leave `sum_o` unchanged.
- R8: `start_i` opens a new vector, clears the running sum and error, and takes priority over a beat in the same cycle. When `len_i` is 0, `done_o` rises in the next cycle with `sum_o` = 0.
- R9: While `rst_ni` is low, `done_o`, `err_o` and `sum_o` are all 0.
- R10: `sum_o` holds its value between `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a vector and samples `len_i` |
| len_i | input | 7 | Element count, 0..MAX_LEN |
| valid_i | input | 1 | Beat present on `wgt_i` / `act_i` |
| wgt_i | input | 8 | Four packed 2-bit ternary codes |
| act_i | input | 32 | Four signed 8-bit activations |
| done_o | output | 1 | One-cycle result strobe |
| sum_o | output | 15 | Signed dot-product result |
| err_o | output | 1 | Reserved code seen in this vector, valid with `done_o` |

## Verification
The hardest situation to reach from the ports is a final beat whose padding lanes carry non-zero and even reserved codes next to extreme activations. The masking must hide these lanes, while in-range lanes keep their effect. The stimulus table contains short vectors of lengths 3 and 5 built this way. Full-length vectors of -128 with all-negative and all-positive codes reach both ends of the accumulator range. They are fed with idle gaps that carry junk data. Restarting a vector that has a reserved code in its abandoned beat shows that the error and sum are cleared.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam int LANES  = 4;
  localparam int ACT_W  = 8;
  localparam int CODE_W = 2;
  localparam int BYTE_W = LANES * CODE_W;
  localparam int TERM_W = ACT_W + 1;

  typedef enum logic [CODE_W-1:0] {
    W_ZERO = 2'b00,
    W_POS  = 2'b01,
    W_BAD  = 2'b10,
    W_NEG  = 2'b11
  } wcode_e;
endpackage

// File: rtl/tern_lane.sv
module tern_lane
  import tern_pkg::*;
(
  input  logic                     en_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic signed [ACT_W-1:0]  act_i,
  output logic signed [TERM_W-1:0] term_o,
  output logic                     bad_o
);
  logic signed [TERM_W-1:0] ext;

  assign ext = TERM_W'(act_i);

  // sign flip, pass or zero: no multiplier
  always_comb begin
    term_o = '0;
    if (en_i) begin
      case (wcode_e'(code_i))
        W_POS:   term_o = ext;
        W_NEG:   term_o = -ext;
        default: term_o = '0;
      endcase
    end
  end

  assign bad_o = en_i && (wcode_e'(code_i) == W_BAD);
endmodule

// File: rtl/tern_adder_tree.sv
module tern_adder_tree #(
  parameter int N     = 4,
  parameter int IN_W  = 9,
  parameter int LVLS  = $clog2(N),
  parameter int OUT_W = IN_W + LVLS
) (
  input  logic signed [IN_W-1:0]  in_i [N],
  output logic signed [OUT_W-1:0] sum_o
);
  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int CNT = N >> l;
    logic signed [OUT_W-1:0] s [CNT];
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < CNT; k++) begin : g_in
        assign s[k] = OUT_W'(in_i[k]);
      end
    end else begin : g_node
      for (genvar k = 0; k < CNT; k++) begin : g_add
        assign s[k] = g_lvl[l-1].s[2*k] + g_lvl[l-1].s[2*k+1];
      end
    end
  end

  assign sum_o = g_lvl[LVLS].s[0];
endmodule

// File: rtl/tern_len_track.sv
module tern_len_track
  import tern_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             valid_i,
  output logic             busy_o,
  output logic             beat_o,
  output logic             last_o,
  output logic [LANES-1:0] lane_en_o
);
  logic [LEN_W-1:0] rem_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign beat_o = busy_q && valid_i && !start_i;
  assign last_o = rem_q <= LEN_W'(LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_en
    assign lane_en_o[k] = rem_q > LEN_W'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= len_i;
      busy_q <= len_i != '0;
    end else if (beat_o) begin
      if (last_o) begin
        rem_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        rem_q  <= rem_q - LEN_W'(LANES);
      end
    end
  end
endmodule

// File: rtl/tern_dot_engine.sv
module tern_dot_engine
  import tern_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ACC_W   = ACT_W + $clog2(MAX_LEN) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic                    valid_i,
  input  logic [BYTE_W-1:0]       wgt_i,
  input  logic [LANES*ACT_W-1:0]  act_i,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] sum_o,
  output logic                    err_o
);
  localparam int TREE_W = TERM_W + $clog2(LANES);

  logic                     busy, beat, last;
  logic [LANES-1:0]         lane_en, lane_bad;
  logic signed [TERM_W-1:0] term [LANES];
  logic signed [TREE_W-1:0] tree_sum;
  logic signed [ACC_W-1:0]  acc_q, acc_next;
  logic                     err_q, beat_bad;

  tern_len_track #(.LEN_W(LEN_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .len_i    (len_i),
    .valid_i  (valid_i),
    .busy_o   (busy),
    .beat_o   (beat),
    .last_o   (last),
    .lane_en_o(lane_en)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tern_lane u_lane (
      .en_i  (lane_en[k]),
      .code_i(wgt_i[CODE_W*k +: CODE_W]),
      .act_i (act_i[ACT_W*k +: ACT_W]),
      .term_o(term[k]),
      .bad_o (lane_bad[k])
    );
  end

  tern_adder_tree #(.N(LANES), .IN_W(TERM_W)) u_tree (
    .in_i (term),
    .sum_o(tree_sum)
  );

  assign beat_bad = |lane_bad;
  assign acc_next = acc_q + ACC_W'(tree_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      err_q  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      sum_o  <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (start_i) begin
        acc_q <= '0;
        err_q <= 1'b0;
        if (len_i == '0) begin
          done_o <= 1'b1;
          sum_o  <= '0;
        end
      end else if (beat) begin
        if (last) begin
          sum_o  <= acc_next;
          done_o <= 1'b1;
          err_o  <= err_q | beat_bad;
          acc_q  <= '0;
          err_q  <= 1'b0;
        end else begin
          acc_q  <= acc_next;
          err_q  <= err_q | beat_bad;
        end
      end
    end
  end
endmodule

// File: rtl/tern_dot_engine_chk.sv
module tern_dot_engine_chk #(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ACC_W   = 8 + $clog2(MAX_LEN) + 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [LEN_W-1:0]        len_i,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] sum_o,
  input logic                    err_o,
  input logic                    busy_q
);
  localparam int LIM = 128 * MAX_LEN;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(sum_o) <= LIM && int'(sum_o) >= -LIM));

  assert_err_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  assert_no_early_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i != '0) |=> !done_o);

  assert_idle_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> !done_o);

  assert_empty_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i == '0) |=> (done_o && sum_o == '0));

  assert_sum_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sum_o));
endmodule

bind tern_dot_engine tern_dot_engine_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .len_i  (len_i),
  .done_o (done_o),
  .sum_o  (sum_o),
  .err_o  (err_o),
  .busy_q (busy)
);

// File: tb/tern_dot_engine_bench.sv
module tern_dot_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 64;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int ACC_W = 8 + $clog2(MAX_LEN) + 1;
  localparam int NV = 7;

  // codes: 00 zero, 01 +1, 11 -1, 10 reserved; element e at w[2e+:2], a[8e+:8]
  // 0 R1 all +1 | 1 R1 all -1 | 2 R1 mixed | 3 R5 len5, padding non-zero
  // 4 R4 reserved code | 5 R5 len3 extremes, reserved padding | 6 R2 lane order
  localparam int          VLEN [NV] = '{4, 4, 4, 5, 8, 3, 8};
  localparam logic [15:0] VW   [NV] = '{16'h0055, 16'h00FF, 16'h004D, 16'h5755,
                                        16'h5556, 16'h00B5, 16'h0001};
  localparam logic [63:0] VA   [NV] = '{64'h00000000_04030201, 64'h00000000_04030201,
                                        64'h00000000_281E140A, 64'h64646405_01010101,
                                        64'h03030303_03030303, 64'h00000000_7F807F80,
                                        64'h09090909_09090907};
  localparam int          VEXP [NV] = '{10, -10, 30, -1, 21, 127, 7};
  localparam logic        VERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic valid_i = 1'b0;
  logic [7:0] wgt_i = '0;
  logic [31:0] act_i = '0;
  logic done_o, err_o;
  logic signed [ACC_W-1:0] sum_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tern_dot_engine #(.MAX_LEN(MAX_LEN)) u_tern_dot_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .valid_i(valid_i), .wgt_i(wgt_i), .act_i(act_i),
    .done_o(done_o), .sum_o(sum_o), .err_o(err_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_vec(input int len);
    start_i = 1'b1;
    len_i = LEN_W'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_beat(input logic [7:0] w, input logic [31:0] a);
    valid_i = 1'b1;
    wgt_i = w;
    act_i = a;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic check_result(input string req, input int exp, input logic exp_err);
    chk(done_o == 1'b1, {req, " done"}, int'(done_o), 1);
    chk(int'(sum_o) == exp, {req, " sum"}, int'(sum_o), exp);
    chk(err_o == exp_err, {req, " err"}, int'(err_o), int'(exp_err));
    @(negedge clk);
    chk(done_o == 1'b0, "R6 single pulse", int'(done_o), 0);
    chk(err_o == 1'b0, "R4 err only with done", int'(err_o), 0);
  endtask

  task automatic run_uniform(input int len, input logic [1:0] code, input logic [7:0] a,
                             input int stall, input int exp);
    int nb;
    nb = (len + 3) / 4;
    start_vec(len);
    for (int b = 0; b < nb; b++) begin
      if (stall > 0 && b > 0) begin
        wgt_i = 8'h55;
        act_i = 32'h7F7F7F7F;
        repeat (stall) begin
          @(negedge clk);
          chk(done_o == 1'b0, "R7 stall no done", int'(done_o), 0);
        end
      end
      send_beat({4{code}}, {4{a}});
      if (b < nb - 1) chk(done_o == 1'b0, "R6 no early done", int'(done_o), 0);
    end
    check_result("R3", exp, 1'b0);
  endtask

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R9 reset done", int'(done_o), 0);
    chk(sum_o == '0, "R9 reset sum", int'(sum_o), 0);
    chk(err_o == 1'b0, "R9 reset err", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      int nb;
      nb = (VLEN[i] + 3) / 4;
      start_vec(VLEN[i]);
      for (int b = 0; b < nb; b++) begin
        send_beat(VW[i][8*b +: 8], VA[i][32*b +: 32]);
        if (b < nb - 1) chk(done_o == 1'b0, "R6 no early done", int'(done_o), 0);
      end
      check_result($sformatf("R1/R2/R4/R5 vec %0d", i), VEXP[i], VERR[i]);
    end

    // R3 extremes, R7 gaps with junk data
    run_uniform(MAX_LEN, 2'b11, 8'h80, 2, 128 * MAX_LEN);
    run_uniform(MAX_LEN, 2'b01, 8'h80, 0, -128 * MAX_LEN);

    // R7 and R10: beats while idle are ignored, sum holds
    held = int'(sum_o);
    for (int c = 0; c < 5; c++) begin
      send_beat(8'h55, 32'h64646464);
      chk(done_o == 1'b0, "R7 idle beat no done", int'(done_o), 0);
      chk(int'(sum_o) == held, "R10 sum holds", int'(sum_o), held);
    end

    // R8 restart clears sum and error
    start_vec(8);
    send_beat(8'h56, 32'h32323232);
    start_vec(4);
    send_beat(8'h55, 32'h04030201);
    check_result("R8 restart", 10, 1'b0);

    // R8 empty vector
    start_vec(0);
    chk(done_o == 1'b1, "R8 len0 done", int'(done_o), 1);
    chk(sum_o == '0, "R8 len0 sum", int'(sum_o), 0);
    @(negedge clk);

    // R9 reset mid-vector
    start_vec(8);
    send_beat(8'h55, 32'h10101010);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0 && err_o == 1'b0, "R9 mid reset flags", int'(done_o), 0);
    chk(sum_o == '0, "R9 mid reset sum", int'(sum_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    start_vec(4);
    send_beat(8'h55, 32'h04030201);
    check_result("R9 after reset", 10, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule